// File: doc/BRIEF.md
# Two-Dimensional Even-Parity Encoder and Single-Error Corrector

This block guards a data word laid out as a grid of `ROWS` rows by `COLS` columns. Data bit `r*COLS + c` sits at row `r`, column `c`. The encode path registers one even-parity bit for each row and one for each column. It also registers a corner bit that covers the parity bits themselves. The check field is therefore `ROWS + COLS + 1` bits wide.

The decode path takes a received word and its received check field. It recomputes every row and column parity and forms syndromes from the mismatches, then sorts the syndrome pattern into one of these outcomes:

- clean;
- one bad data bit;
- one bad row-parity bit;
- one bad column-parity bit;
- a bad corner bit;
- not correctable.

A single bad data bit lies where the failing row and the failing column cross, and the block inverts that bit. A single bad check bit is repaired, which leaves the data as received. Every other pattern is flagged as uncorrectable and the data passes through unchanged.

Both paths register their results, so each output appears one clock after its input strobe. The encode and decode paths are independent, so a sender and a receiver can share one instance.

Top module: `grid_parity_codec`

## Requirements
- R1: When `enc_valid_in` is high, `enc_row_par[r]` on the next cycle equals the XOR of data bits `r*COLS` through `r*COLS+COLS-1`.
- R2: When `enc_valid_in` is high, `enc_col_par[c]` on the next cycle equals the XOR of data bits `c`, `c+COLS`, `c+2*COLS` and so on, one bit from each row.
- R3: `enc_corner` equals the XOR of all row parity bits, which is also the XOR of all column parity bits.
- R4: `enc_valid_out` is high exactly one cycle after `enc_valid_in`. The encode outputs change only after a cycle with `enc_valid_in` high and hold their value otherwise.
- R5: A received word whose check field matches gives back the same data, with `dec_corrected` and `dec_uncorrectable` both low.
- R6: A single inverted data bit is restored, and `dec_corrected` goes high with `dec_uncorrectable` low.
- R7: A single inverted row-parity or column-parity bit leaves the data unchanged and raises only `dec_corrected`.
- R8: An inverted corner bit alone leaves the data unchanged and raises only `dec_corrected`.
- R9: Any two inverted bits anywhere in the data or the check field raise `dec_uncorrectable` and leave `dec_corrected` low. The data then passes through exactly as received.
- R10: `dec_valid_out` is high exactly in the cycle after a cycle with `dec_valid_in` high.
- R11: While `rst` is high, every registered output is driven to zero on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_in | input | 1 | Encode request strobe |
| enc_data_in | input | ROWS*COLS | Word to encode, row-major |
| enc_valid_out | output | 1 | Encode result strobe |
| enc_row_par | output | ROWS | Row parity bits |
| enc_col_par | output | COLS | Column parity bits |
| enc_corner | output | 1 | Parity over the row parity bits |
| dec_valid_in | input | 1 | Decode request strobe |
| dec_data_in | input | ROWS*COLS | Received word |
| dec_row_par_in | input | ROWS | Received row parity bits |
| dec_col_par_in | input | COLS | Received column parity bits |
| dec_corner_in | input | 1 | Received corner bit |
| dec_valid_out | output | 1 | Decode result strobe |
| dec_data_out | output | ROWS*COLS | Corrected word |
| dec_corrected | output | 1 | A single error was repaired |
| dec_uncorrectable | output | 1 | Error detected but not repairable |

## Verification
Two internal faults show up as a bad flag in the same cycle `dec_valid_out` rises:

- If a syndrome bit is computed wrongly, a clean word is reported as corrected or uncorrectable.
- If the row or column index is decoded wrongly, the output word differs from the sent word in two places rather than none.

Every decision is visible at the ports one cycle after its input strobe, because no state carries from one word to the next. A table of single and double inversions therefore exposes each fault on the first vector that touches it. Encoder faults show up as a parity mismatch on the cycle after `enc_valid_in`.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [2:0] {
    CLS_CLEAN  = 3'd0,
    CLS_DATA   = 3'd1,
    CLS_ROWP   = 3'd2,
    CLS_COLP   = 3'd3,
    CLS_CORNER = 3'd4,
    CLS_FAIL   = 3'd5
  } err_class_e;
endpackage

// File: rtl/gpc_parity_gen.sv
module gpc_parity_gen #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic [ROWS*COLS-1:0] data,
  output logic [ROWS-1:0]      row_par,
  output logic [COLS-1:0]      col_par
);
  for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
    assign row_par[gr] = ^data[gr*COLS +: COLS];
  end

  for (genvar gc = 0; gc < COLS; gc++) begin : g_col
    logic [ROWS-1:0] column;
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_pick
      assign column[gr] = data[gr*COLS + gc];
    end
    assign col_par[gc] = ^column;
  end
endmodule

// File: rtl/gpc_classify.sv
module gpc_classify
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [ROWS-1:0] row_syn,
  input  logic [COLS-1:0] col_syn,
  input  logic            corner_vs_rows,
  input  logic            corner_vs_cols,
  output err_class_e      cls,
  output logic [RW-1:0]   row_idx,
  output logic [CW-1:0]   col_idx
);
  logic row_none, col_none, row_one, col_one;

  always_comb begin
    row_idx = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_syn[r]) row_idx = RW'(r);
    end
    col_idx = '0;
    for (int c = 0; c < COLS; c++) begin
      if (col_syn[c]) col_idx = CW'(c);
    end
  end

  assign row_none = (row_syn == '0);
  assign col_none = (col_syn == '0);
  assign row_one  = ($countones(row_syn) == 1);
  assign col_one  = ($countones(col_syn) == 1);

  always_comb begin
    if (row_none && col_none && !corner_vs_rows && !corner_vs_cols)
      cls = CLS_CLEAN;
    else if (row_one && col_one && !corner_vs_rows && !corner_vs_cols)
      cls = CLS_DATA;
    else if (row_one && col_none && corner_vs_rows && !corner_vs_cols)
      cls = CLS_ROWP;
    else if (row_none && col_one && !corner_vs_rows && corner_vs_cols)
      cls = CLS_COLP;
    else if (row_none && col_none && corner_vs_rows && corner_vs_cols)
      cls = CLS_CORNER;
    else
      cls = CLS_FAIL;
  end
endmodule

// File: rtl/gpc_corrector.sv
module gpc_corrector
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [ROWS*COLS-1:0] data_in,
  input  err_class_e           cls,
  input  logic [RW-1:0]        row_idx,
  input  logic [CW-1:0]        col_idx,
  output logic [ROWS*COLS-1:0] data_fix,
  output logic                 corrected,
  output logic                 uncorrectable
);
  logic [ROWS*COLS-1:0] flip;

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_r
    for (genvar gc = 0; gc < COLS; gc++) begin : g_c
      assign flip[gr*COLS + gc] = (cls == CLS_DATA) &&
                                  (row_idx == RW'(gr)) && (col_idx == CW'(gc));
    end
  end

  assign data_fix      = data_in ^ flip;
  assign corrected     = (cls != CLS_CLEAN) && (cls != CLS_FAIL);
  assign uncorrectable = (cls == CLS_FAIL);
endmodule

// File: rtl/grid_parity_codec.sv
module grid_parity_codec
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enc_valid_in,
  input  logic [ROWS*COLS-1:0] enc_data_in,
  output logic                 enc_valid_out,
  output logic [ROWS-1:0]      enc_row_par,
  output logic [COLS-1:0]      enc_col_par,
  output logic                 enc_corner,
  input  logic                 dec_valid_in,
  input  logic [ROWS*COLS-1:0] dec_data_in,
  input  logic [ROWS-1:0]      dec_row_par_in,
  input  logic [COLS-1:0]      dec_col_par_in,
  input  logic                 dec_corner_in,
  output logic                 dec_valid_out,
  output logic [ROWS*COLS-1:0] dec_data_out,
  output logic                 dec_corrected,
  output logic                 dec_uncorrectable
);
  localparam int DW = ROWS * COLS;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  // encode path
  logic [ROWS-1:0] e_row;
  logic [COLS-1:0] e_col;

  gpc_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_enc_par (
    .data(enc_data_in), .row_par(e_row), .col_par(e_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_out <= 1'b0;
      enc_row_par   <= '0;
      enc_col_par   <= '0;
      enc_corner    <= 1'b0;
    end else begin
      enc_valid_out <= enc_valid_in;
      if (enc_valid_in) begin
        enc_row_par <= e_row;
        enc_col_par <= e_col;
        enc_corner  <= ^e_row;
      end
    end
  end

  // decode path
  logic [ROWS-1:0] d_row;
  logic [COLS-1:0] d_col;
  logic [ROWS-1:0] row_syn;
  logic [COLS-1:0] col_syn;
  logic            cs_rows, cs_cols;
  err_class_e      cls;
  logic [RW-1:0]   row_idx;
  logic [CW-1:0]   col_idx;
  logic [DW-1:0]   data_fix;
  logic            fix_ok, fix_bad;

  gpc_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_dec_par (
    .data(dec_data_in), .row_par(d_row), .col_par(d_col)
  );

  assign row_syn = d_row ^ dec_row_par_in;
  assign col_syn = d_col ^ dec_col_par_in;
  assign cs_rows = (^dec_row_par_in) ^ dec_corner_in;
  assign cs_cols = (^dec_col_par_in) ^ dec_corner_in;

  gpc_classify #(.ROWS(ROWS), .COLS(COLS)) u_cls (
    .row_syn(row_syn), .col_syn(col_syn),
    .corner_vs_rows(cs_rows), .corner_vs_cols(cs_cols),
    .cls(cls), .row_idx(row_idx), .col_idx(col_idx)
  );

  gpc_corrector #(.ROWS(ROWS), .COLS(COLS)) u_fix (
    .data_in(dec_data_in), .cls(cls), .row_idx(row_idx), .col_idx(col_idx),
    .data_fix(data_fix), .corrected(fix_ok), .uncorrectable(fix_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_out     <= 1'b0;
      dec_data_out      <= '0;
      dec_corrected     <= 1'b0;
      dec_uncorrectable <= 1'b0;
    end else begin
      dec_valid_out <= dec_valid_in;
      if (dec_valid_in) begin
        dec_data_out      <= data_fix;
        dec_corrected     <= fix_ok;
        dec_uncorrectable <= fix_bad;
      end
    end
  end

  // checks
  AST_CORNER_BALANCE: assert property (@(posedge clk) disable iff (rst)
    enc_valid_out |-> ((^enc_row_par) == (^enc_col_par))); // R3
  AST_ENC_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    enc_valid_in |=> enc_valid_out); // R4
  AST_DEC_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_in |=> !dec_valid_out); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(dec_corrected && dec_uncorrectable)); // R9
  AST_ONE_BIT_FIX: assert property (@(posedge clk) disable iff (rst)
    dec_valid_out |-> ($countones(dec_data_out ^ $past(dec_data_in)) <= 1)); // R6
  AST_FAIL_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_out && dec_uncorrectable) |-> (dec_data_out == $past(dec_data_in))); // R9
endmodule

// File: tb/grid_parity_codec_test.sv
`timescale 1ns/1ps
module grid_parity_codec_test;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = ROWS * COLS;
  localparam int CWW  = DW + ROWS + COLS + 1;
  localparam int NV   = 13;

  // each entry: {data word, inversion mask over {corner, col par, row par, data}}
  localparam logic [DW+CWW-1:0] VEC [NV] = '{
    {16'h0000, 25'h0000000},
    {16'hFFFF, 25'h0000000},
    {16'hA5C3, 25'h0000001},
    {16'h1234, 25'h0008000},
    {16'hBEEF, 25'h0010000},
    {16'h0F0F, 25'h0800000},
    {16'h5A5A, 25'h1000000},
    {16'hC3C3, 25'h0000003},
    {16'h7E81, 25'h0000021},
    {16'h6B2D, 25'h0010001},
    {16'h9876, 25'h0110000},
    {16'h4321, 25'h1100000},
    {16'hFACE, 25'h0100010}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_valid_in = 1'b0;
  logic [DW-1:0] enc_data_in = '0;
  logic enc_valid_out;
  logic [ROWS-1:0] enc_row_par;
  logic [COLS-1:0] enc_col_par;
  logic enc_corner;
  logic dec_valid_in = 1'b0;
  logic [DW-1:0] dec_data_in = '0;
  logic [ROWS-1:0] dec_row_par_in = '0;
  logic [COLS-1:0] dec_col_par_in = '0;
  logic dec_corner_in = 1'b0;
  logic dec_valid_out;
  logic [DW-1:0] dec_data_out;
  logic dec_corrected, dec_uncorrectable;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  grid_parity_codec #(.ROWS(ROWS), .COLS(COLS)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] ref_row(input logic [DW-1:0] d);
    logic [ROWS-1:0] p = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) p[r] ^= d[r*COLS + c];
    return p;
  endfunction

  function automatic logic [COLS-1:0] ref_col(input logic [DW-1:0] d);
    logic [COLS-1:0] p = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) p[c] ^= d[r*COLS + c];
    return p;
  endfunction

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 enc_valid_out", 32'(enc_valid_out), 0);
    chk("R11 dec_valid_out", 32'(dec_valid_out), 0);
    chk("R11 dec_data_out", 32'(dec_data_out), 0);
    chk("R11 flags", {30'd0, dec_corrected, dec_uncorrectable}, 0);
    chk("R11 enc parity", {23'd0, enc_corner, enc_col_par, enc_row_par}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0]  d;
      logic [CWW-1:0] m, cw;
      int n;
      d  = VEC[i][DW+CWW-1:CWW];
      m  = VEC[i][CWW-1:0];
      cw = {^ref_row(d), ref_col(d), ref_row(d), d} ^ m;
      n  = $countones(m);
      enc_valid_in   = 1'b1; enc_data_in = d;
      dec_valid_in   = 1'b1;
      dec_data_in    = cw[DW-1:0];
      dec_row_par_in = cw[DW +: ROWS];
      dec_col_par_in = cw[DW+ROWS +: COLS];
      dec_corner_in  = cw[CWW-1];
      @(negedge clk);
      enc_valid_in = 1'b0; dec_valid_in = 1'b0;
      chk("R1 row parity", 32'(enc_row_par), 32'(ref_row(d)));
      chk("R2 col parity", 32'(enc_col_par), 32'(ref_col(d)));
      chk("R3 corner", 32'(enc_corner), 32'(^ref_col(d)));
      chk("R4 enc valid", 32'(enc_valid_out), 1);
      chk("R10 dec valid", 32'(dec_valid_out), 1);
      if (n == 0) begin
        chk("R5 clean data", 32'(dec_data_out), 32'(d));
        chk("R5 clean flags", {30'd0, dec_corrected, dec_uncorrectable}, 0);
      end else if (n == 1) begin
        chk("R6 R7 R8 data restored", 32'(dec_data_out), 32'(d));
        chk("R6 R7 R8 flags", {30'd0, dec_corrected, dec_uncorrectable}, 2);
      end else begin
        chk("R9 data as received", 32'(dec_data_out), 32'(cw[DW-1:0]));
        chk("R9 flags", {30'd0, dec_corrected, dec_uncorrectable}, 1);
      end
      @(negedge clk);
      chk("R10 dec valid drop", 32'(dec_valid_out), 0);
      chk("R4 enc valid drop", 32'(enc_valid_out), 0);
    end

    // R4 encode outputs hold without a strobe
    held = 16'h3C5A;
    enc_valid_in = 1'b1; enc_data_in = held;
    @(negedge clk);
    enc_valid_in = 1'b0; enc_data_in = 16'h0001;
    @(negedge clk);
    @(negedge clk);
    chk("R4 hold row", 32'(enc_row_par), 32'(ref_row(held)));
    chk("R4 hold col", 32'(enc_col_par), 32'(ref_col(held)));

    // R6 every data position, one at a time, on an all-ones word
    for (int b = 0; b < DW; b++) begin
      logic [DW-1:0] d;
      d = '1;
      dec_valid_in = 1'b1;
      dec_data_in = d ^ (DW'(1) << b);
      dec_row_par_in = ref_row(d); dec_col_par_in = ref_col(d);
      dec_corner_in = ^ref_row(d);
      @(negedge clk);
      dec_valid_in = 1'b0;
      chk("R6 sweep data", 32'(dec_data_out), 32'(d));
      chk("R6 sweep corrected", 32'(dec_corrected), 1);
    end

    // R11 reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R11 re-reset data", 32'(dec_data_out), 0);
    chk("R11 re-reset enc", 32'(enc_row_par), 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule